// File: doc/BRIEF.md
# Page Write Timer and Toggle Poller

This block sits between a host bus and a two-plane nonvolatile array. Host writes are collected into a page buffer. All bytes of one page share one 32-byte row. Each accepted byte restarts a load window. When the window runs out with no further byte, the block enters a timed programming phase for the plane that holds the row. During that phase it copies only the loaded bytes into the array.

While one plane is programming, a read to that plane returns a status byte. One bit of that byte flips on every such read, so the host can poll for completion. A read to the other plane returns real array contents in the same cycle budget. A high level on the write-inhibit input kills a page that is still loading, and it also refuses new writes. All time limits are parameters counted in clock cycles, so a simulation can use short values.

The plane is selected by the most significant address bit. The page row is selected by the address bits above the low `OFS_W` offset bits. A simple flop-based array model is included so that committed data can be read back.

Top module: `page_prog_engine`

## Requirements
- R1: After reset `busy` is 2'b00, `rd_valid` and `rd_sel` are 0, and every array location reads back as 0.
- R2: A write with `wr_inhibit` low while idle opens a page. If no further byte is accepted, `busy` for the plane of that row rises exactly `LOAD_CYC` cycles after the accepting edge and stays high for exactly `PROG_CYC` cycles.
- R3: Every accepted byte restarts the load window, so programming starts `LOAD_CYC` cycles after the last accepted byte.
- R4: While a page is loading, a write whose row bits (`wr_addr[ADDR_W-1:OFS_W]`) differ from the open row is dropped. It neither stores data nor restarts the load window.
- R5: While a page is loading, a write that arrives fewer than `SPACE_CYC` cycles after the previous accepted byte is dropped. One that arrives exactly `SPACE_CYC` cycles later is accepted.
- R6: Programming writes only the offsets that were loaded, and the other locations of the row keep their old value. When one offset is loaded twice, the later byte is the one written.
- R7: `wr_inhibit` high while a page is loading discards the page: `busy` never rises and the array is unchanged. A write presented while `wr_inhibit` is high in the idle state is refused.
- R8: During programming, a read whose top address bit matches the busy plane returns a byte that is 0 except bit `TOG_BIT`, with `rd_sel` = 1. That bit is 0 on the first such read after reset and inverts on each later such read. Once programming ends, the same reads return array data with `rd_sel` = 0.
- R9: A read to the plane that is not programming returns true array data with `rd_sel` = 0. A read during page loading returns the array contents, not the pending buffer.
- R10: Writes presented while either plane is programming are dropped, whichever plane they address.
- R11: Each `rd_stb` gives `rd_valid` = 1 with its data on the following cycle, and `rd_valid` is 0 in the cycle after a cycle without `rd_stb`.
- R12: At most one bit of `busy` is set. The set bit equals the top address bit of the programmed row, and it does not move to the other plane while high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle accepted bus write pulse |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write byte |
| wr_inhibit | input | 1 | High refuses writes and aborts a loading page |
| rd_stb | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_stb` |
| rd_sel | output | 1 | 1 when the result is the status byte, 0 when it is array data |
| rd_data | output | DATA_W | Read result |
| busy | output | 2 | Per-plane programming flag, bit index = plane |
| commit_en | output | 1 | Array write strobe during programming |
| commit_addr | output | ADDR_W | Array write address |
| commit_data | output | DATA_W | Array write byte |

## Verification
The bench builds the block with a 10-bit address (two planes of 512 bytes), a 40-cycle load window, a 4-cycle byte spacing and a 100-cycle programming phase. With these values the exact rise and fall cycle of `busy` can be checked against the last accepted byte. The spacing limit can be probed one cycle below and at its value. A late byte can be placed two cycles before the window would close. Full 32-byte rows in both planes can also be read back, including polls and cross-plane reads made while a plane is busy.

// File: rtl/ppe_pkg.sv
`timescale 1ns/1ps
package ppe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ppe_state_e;
endpackage

// File: rtl/ppe_cdown.sv
`timescale 1ns/1ps
// Loadable down counter; zero flag marks an elapsed window.
module ppe_cdown #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = W'(LIMIT - 1);
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ppe_page_buf.sv
`timescale 1ns/1ps
// Row buffer with per-byte valid mask and serial commit walker.
module ppe_page_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS_W  = 5,
  parameter int unsigned TAG_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    store,
  input  logic [OFS_W-1:0]        store_ofs,
  input  logic [DATA_W-1:0]       store_data,
  input  logic                    run,
  input  logic [TAG_W-1:0]        tag,
  output logic                    commit_en,
  output logic [TAG_W+OFS_W-1:0]  commit_addr,
  output logic [DATA_W-1:0]       commit_data
);
  localparam int unsigned NB = 1 << OFS_W;

  logic [DATA_W-1:0] data_q [NB];
  logic [NB-1:0]     vld_q, vld_d;
  logic [OFS_W:0]    idx_q, idx_d;
  logic [OFS_W-1:0]  idx_lo;

  assign idx_lo = idx_q[OFS_W-1:0];

  always_comb begin
    vld_d = clear ? '0 : vld_q;
    if (store) vld_d[store_ofs] = 1'b1;
    idx_d = '0;
    if (run) idx_d = idx_q[OFS_W] ? idx_q : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  // Data storage: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (store) data_q[store_ofs] <= store_data;
  end

  assign commit_en   = run && !idx_q[OFS_W] && vld_q[idx_lo];
  assign commit_addr = {tag, idx_lo};
  assign commit_data = data_q[idx_lo];
endmodule

// File: rtl/ppe_rd_port.sv
`timescale 1ns/1ps
// Registered read return: array data or toggling status byte.
module ppe_rd_port #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TOG_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              poll_hit,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_valid,
  output logic              rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic              tog_q, tog_d;
  logic              vld_q, sel_q, sel_d;
  logic [DATA_W-1:0] dat_q, dat_d, status;

  always_comb begin
    status          = '0;
    status[TOG_BIT] = tog_q;
    sel_d           = rd_stb && poll_hit;
    tog_d           = sel_d ? ~tog_q : tog_q;
    dat_d           = dat_q;
    if (rd_stb) dat_d = poll_hit ? status : arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      vld_q <= 1'b0;
      sel_q <= 1'b0;
      dat_q <= '0;
    end else begin
      tog_q <= tog_d;
      vld_q <= rd_stb;
      sel_q <= sel_d;
      dat_q <= dat_d;
    end
  end

  assign rd_valid = vld_q;
  assign rd_sel   = sel_q;
  assign rd_data  = dat_q;
endmodule

// File: rtl/ppe_array.sv
`timescale 1ns/1ps
// Simple flop array standing in for the nonvolatile planes.
module ppe_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/page_prog_engine.sv
`timescale 1ns/1ps
// Page load / program sequencer with concurrent status polling.
// PROG_CYC must be at least 2**OFS_W so the serial commit completes.
module page_prog_engine #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OFS_W     = 5,
  parameter int unsigned LOAD_CYC  = 5000,
  parameter int unsigned SPACE_CYC = 25,
  parameter int unsigned PROG_CYC  = 250000,
  parameter int unsigned TOG_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_inhibit,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        busy,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  import ppe_pkg::*;

  localparam int unsigned TAG_W = ADDR_W - OFS_W;
  localparam int unsigned PLANE = ADDR_W - 1;

  ppe_state_e       st_q, st_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [TAG_W-1:0] wr_tag;
  logic             acc_open, acc_add, store, go_prog;
  logic             ld_zero, sp_zero, pg_zero;
  logic             poll_hit;
  logic [DATA_W-1:0] arr_rdata;

  assign wr_tag   = wr_addr[ADDR_W-1:OFS_W];
  assign acc_open = (st_q == ST_IDLE) && wr_stb && !wr_inhibit;
  assign acc_add  = (st_q == ST_LOAD) && wr_stb && !wr_inhibit &&
                    (wr_tag == tag_q) && sp_zero;
  assign store    = acc_open || acc_add;

  // Next-state logic: abort outranks a new byte, a new byte outranks expiry.
  always_comb begin
    st_d  = st_q;
    tag_d = tag_q;
    case (st_q)
      ST_IDLE: begin
        if (acc_open) begin
          st_d  = ST_LOAD;
          tag_d = wr_tag;
        end
      end
      ST_LOAD: begin
        if (wr_inhibit)    st_d = ST_IDLE;
        else if (acc_add)  st_d = ST_LOAD;
        else if (ld_zero)  st_d = ST_PROG;
      end
      ST_PROG: begin
        if (pg_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign go_prog = (st_q == ST_LOAD) && (st_d == ST_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tag_q <= '0;
    end else begin
      st_q  <= st_d;
      tag_q <= tag_d;
    end
  end

  // Byte-load window, restarted by every stored byte.
  ppe_cdown #(.LIMIT(LOAD_CYC)) u_load_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(store), .dec(st_q == ST_LOAD), .zero(ld_zero)
  );

  // Minimum spacing between stored bytes.
  ppe_cdown #(.LIMIT(SPACE_CYC)) u_space_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(store), .dec(1'b1), .zero(sp_zero)
  );

  // Programming phase length.
  ppe_cdown #(.LIMIT(PROG_CYC)) u_prog_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(go_prog), .dec(st_q == ST_PROG), .zero(pg_zero)
  );

  ppe_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W), .TAG_W(TAG_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .clear(st_q == ST_IDLE),
    .store(store),
    .store_ofs(wr_addr[OFS_W-1:0]),
    .store_data(wr_data),
    .run(st_q == ST_PROG),
    .tag(tag_q),
    .commit_en(commit_en),
    .commit_addr(commit_addr),
    .commit_data(commit_data)
  );

  for (genvar p = 0; p < 2; p++) begin : g_busy
    assign busy[p] = (st_q == ST_PROG) && (tag_q[TAG_W-1] == 1'(p));
  end

  assign poll_hit = (st_q == ST_PROG) && (rd_addr[PLANE] == tag_q[TAG_W-1]);

  ppe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(commit_en), .waddr(commit_addr), .wdata(commit_data),
    .raddr(rd_addr), .rdata(arr_rdata)
  );

  ppe_rd_port #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_stb(rd_stb), .poll_hit(poll_hit), .arr_data(arr_rdata),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_data(rd_data)
  );
endmodule

// File: rtl/ppe_chk.sv
`timescale 1ns/1ps
module ppe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] busy,
  input logic       wr_inhibit,
  input logic       rd_stb,
  input logic       rd_valid,
  input logic       rd_sel,
  input logic       commit_en
);
  // R12
  busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));

  // R12
  busy_plane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != 2'b00) |=> ((busy == 2'b00) || $stable(busy)));

  // R7
  inhibit_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inhibit && (busy == 2'b00)) |=> (busy == 2'b00));

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);

  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);

  // R8
  poll_sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> rd_valid);

  // R6
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (busy != 2'b00));
endmodule

bind page_prog_engine ppe_chk u_ppe_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_inhibit(wr_inhibit),
  .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_sel(rd_sel),
  .commit_en(commit_en)
);

// File: tb/page_prog_engine_bench.sv
`timescale 1ns/1ps
module page_prog_engine_bench;
  localparam int L = 40;
  localparam int S = 4;
  localparam int P = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb, wr_inhibit, rd_stb;
  logic [9:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic       rd_valid, rd_sel, commit_en;
  logic [7:0] rd_data, commit_data;
  logic [9:0] commit_addr;
  logic [1:0] busy;

  int  n_chk = 0;
  int  n_err = 0;
  logic [7:0] shadow [1024];
  logic tog_exp = 1'b0;

  always #5 clk = ~clk;

  page_prog_engine #(
    .ADDR_W(10), .DATA_W(8), .OFS_W(5), .LOAD_CYC(L),
    .SPACE_CYC(S), .PROG_CYC(P), .TOG_BIT(6)
  ) u_page_prog_engine (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_inhibit(wr_inhibit), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_sel(rd_sel),
    .rd_data(rd_data), .busy(busy), .commit_en(commit_en),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; sampled at the next posedge.
  task automatic do_write(input logic [9:0] a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, output logic [7:0] d,
                         output logic s, output logic v);
    rd_stb = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data; s = rd_sel; v = rd_valid;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    bit fin  = 1'b0;
    for (int i = 0; i < L + P + 20; i++) begin
      @(negedge clk);
      if (busy != 2'b00) seen = 1'b1;
      else if (seen) begin fin = 1'b1; break; end
    end
    chk(req, "programming completed", int'(fin), 1);
  endtask

  task automatic check_row(input logic [9:0] base, input string req);
    logic [7:0] d; logic s, v;
    for (int i = 0; i < 32; i++) begin
      do_read(base + 10'(i), d, s, v);
      chk(req, $sformatf("row data @%0h", base + 10'(i)), int'(d), int'(shadow[base + 10'(i)]));
      chk(req, "row rd_sel", int'(s), 0);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d; logic s, v;
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(10'h3FF, d, s, v);
    chk("R1", "array cleared", int'(d), 0);
    chk("R11", "rd_valid after read", int'(v), 1);
    @(negedge clk);
    chk("R11", "rd_valid idle", int'(rd_valid), 0);
  endtask

  task automatic t_basic;
    do_write(10'h041, 8'hA1);
    repeat (S) @(negedge clk);
    do_write(10'h045, 8'hB2);
    repeat (S) @(negedge clk);
    do_write(10'h05F, 8'hC3);
    repeat (L - 1) @(negedge clk);
    chk("R2", "busy before window end", int'(busy), 0);
    @(negedge clk);
    chk("R2", "busy plane0 at window end", int'(busy), 1);
    repeat (P - 1) @(negedge clk);
    chk("R2", "busy last programming cycle", int'(busy), 1);
    @(negedge clk);
    chk("R2", "busy after programming", int'(busy), 0);
    shadow[10'h041] = 8'hA1; shadow[10'h045] = 8'hB2; shadow[10'h05F] = 8'hC3;
    check_row(10'h040, "R6");
  endtask

  task automatic t_overwrite;
    logic [7:0] d; logic s, v;
    do_write(10'h045, 8'h11);
    repeat (S - 1) @(negedge clk);
    do_write(10'h045, 8'h22);
    do_read(10'h045, d, s, v);
    chk("R9", "read during load returns array", int'(d), 8'hB2);
    wait_done("R6");
    shadow[10'h045] = 8'h22;
    check_row(10'h040, "R6");
  endtask

  task automatic t_restart;
    do_write(10'h0A0, 8'h31);
    repeat (L - 3) @(negedge clk);
    do_write(10'h0A1, 8'h32);
    repeat (2) @(negedge clk);
    chk("R3", "no busy at first window end", int'(busy), 0);
    repeat (L - 3) @(negedge clk);
    chk("R3", "busy before restarted end", int'(busy), 0);
    @(negedge clk);
    chk("R3", "busy at restarted end", int'(busy), 1);
    wait_done("R3");
    shadow[10'h0A0] = 8'h31; shadow[10'h0A1] = 8'h32;
    check_row(10'h0A0, "R3");
  endtask

  task automatic t_tag;
    logic [7:0] d; logic s, v;
    do_write(10'h0E0, 8'h99);
    repeat (L - 3) @(negedge clk);
    do_write(10'h120, 8'hAB);
    @(negedge clk);
    chk("R4", "busy before first end", int'(busy), 0);
    @(negedge clk);
    chk("R4", "window not restarted by foreign row", int'(busy), 1);
    wait_done("R4");
    shadow[10'h0E0] = 8'h99;
    do_read(10'h120, d, s, v);
    chk("R4", "foreign row byte not written", int'(d), 0);
    do_read(10'h0E0, d, s, v);
    chk("R4", "open row byte written", int'(d), 8'h99);
  endtask

  task automatic t_spacing;
    do_write(10'h0C0, 8'h44);
    do_write(10'h0C1, 8'h55);
    repeat (S - 3) @(negedge clk);
    do_write(10'h0C2, 8'h66);
    do_write(10'h0C3, 8'h77);
    wait_done("R5");
    shadow[10'h0C0] = 8'h44; shadow[10'h0C3] = 8'h77;
    check_row(10'h0C0, "R5");
  endtask

  task automatic t_abort;
    logic [7:0] d; logic s, v;
    int hits = 0;
    do_write(10'h081, 8'h11);
    wr_inhibit = 1'b1;
    @(negedge clk);
    wr_inhibit = 1'b0;
    for (int i = 0; i < L + P + 10; i++) begin
      @(negedge clk);
      if (busy != 2'b00) hits++;
    end
    chk("R7", "aborted page never programs", hits, 0);
    do_read(10'h081, d, s, v);
    chk("R7", "aborted byte absent", int'(d), 0);
    wr_inhibit = 1'b1;
    do_write(10'h082, 8'h22);
    wr_inhibit = 1'b0;
    repeat (L + 5) @(negedge clk);
    chk("R7", "inhibited write starts nothing", int'(busy), 0);
    do_read(10'h082, d, s, v);
    chk("R7", "inhibited byte absent", int'(d), 0);
  endtask

  task automatic t_poll;
    logic [7:0] d; logic s, v;
    do_write(10'h261, 8'h5A);
    repeat (S - 1) @(negedge clk);
    do_write(10'h262, 8'h66);
    for (int i = 0; i < L + 5; i++) begin
      @(negedge clk);
      if (busy != 2'b00) break;
    end
    chk("R12", "plane1 busy flag", int'(busy), 2);
    for (int k = 0; k < 3; k++) begin
      do_read(10'h261, d, s, v);
      chk("R8", "poll status byte", int'(d), tog_exp ? 8'h40 : 8'h00);
      chk("R8", "poll rd_sel", int'(s), 1);
      tog_exp = ~tog_exp;
    end
    do_read(10'h041, d, s, v);
    chk("R9", "other plane true data", int'(d), 8'hA1);
    chk("R9", "other plane rd_sel", int'(s), 0);
    do_write(10'h100, 8'h77);
    do_write(10'h270, 8'h88);
    wait_done("R8");
    repeat (L + 5) @(negedge clk);
    chk("R10", "no page from writes during programming", int'(busy), 0);
    do_read(10'h100, d, s, v);
    chk("R10", "plane0 write dropped", int'(d), 0);
    do_read(10'h270, d, s, v);
    chk("R10", "plane1 write dropped", int'(d), 0);
    do_read(10'h261, d, s, v);
    chk("R8", "true data after programming", int'(d), 8'h5A);
    chk("R8", "status off after programming", int'(s), 0);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = 8'h00;
    rst_n = 1'b0; wr_stb = 1'b0; wr_inhibit = 1'b0; rd_stb = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_overwrite();
    t_restart();
    t_tag();
    t_spacing();
    t_abort();
    t_poll();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule